// File: doc/BRIEF.md
# Per-Bank Command Occupancy Checker

This block gates read and precharge commands against the memory banks they target. A command already issued to a bank keeps that bank busy for a while. The length of that busy time depends on the command type. The block stores, for each bank, the cycle at which the last issued command ends, and whether any command has been recorded there since reset.

A scheduler proposes a command by presenting its kind, bank and intended start cycle on the query port. One cycle later the block returns the earliest legal start. This is the proposed cycle, pushed out to the stored end cycle when the bank is still busy. When the scheduler commits a command, it presents the command on the issue port and the block records the new end cycle: start plus the duration for that type.

Cycle values are absolute counts owned by the scheduler. They are compared unsigned and are assumed not to wrap.

The control is a two-state machine. `ST_IDLE` means no answer is pending. `ST_ANSWER` means the answer register holds a result and `ans_valid` is high. The transitions are:
- `ST_IDLE` → `ST_ANSWER` on a query.
- `ST_ANSWER` → `ST_ANSWER` on a back-to-back query.
- `ST_ANSWER` → `ST_IDLE` when no query is present.

Top module: `occ_checker`

## Requirements
- R1: After reset, every bank is unrecorded and `ans_valid` is low.
- R2: A query accepted at a clock edge makes `ans_valid` high for exactly the following cycle, with `ans_start` holding that query's answer. `ans_valid` is low in any cycle that does not follow a query.
- R3: A read query (`qry_kind` = 1) on a recorded bank returns the larger of `qry_start` and that bank's stored end cycle.
- R4: A precharge query (`qry_kind` = 3) on a recorded bank follows the same rule as R3. A read that ends at cycle E makes a precharge proposed before E start exactly at E.
- R5: A query on a bank with no recorded command returns `qry_start` unchanged.
- R6: An issued command stores end = start + duration, with these durations:
  - activate (code 0): `T_RCD` = 3
  - read (code 1): `T_RL` + `T_RDATA` = 3 + 2 = 5
  - write (code 2): `T_WR` = 8
  - precharge (code 3): `T_RP` = 4
- R7: An issued precharge-all (code 4) sets the end cycle of every bank to start + `T_RP` and marks every bank recorded.
- R8: A precharge-all query (code 4) returns the larger of `qry_start` and the latest stored end over all recorded banks. `qry_bank` is ignored for this query.
- R9: The stored end for a bank is the end of the most recently issued command, even when that end is earlier than the previously stored end.
- R10: A query of kind activate (0) or write (2) returns `qry_start` unchanged.
- R11: A query sees the table as it stood before an issue presented in the same cycle.
- R12: An issue with an unused code (5, 6 or 7) leaves every bank's stored end and recorded flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qry_valid | input | 1 | A query is present this cycle |
| qry_kind | input | 3 | Command code of the query |
| qry_bank | input | BANK_W (3) | Target bank of the query |
| qry_start | input | TIME_W (16) | Proposed start cycle |
| iss_valid | input | 1 | A command is issued this cycle |
| iss_cmd | input | 3 | Command code of the issued command |
| iss_bank | input | BANK_W (3) | Bank of the issued command |
| iss_start | input | TIME_W (16) | Start cycle of the issued command |
| ans_valid | output | 1 | An answer is present this cycle |
| ans_start | output | TIME_W (16) | Earliest legal start for the previous query |

## Verification
The assertions check several behaviours on every cycle:
- the one-cycle answer timing and the absence of spurious answers;
- that an answer is never earlier than the proposed start;
- that activate and write queries pass through untouched.

Only the bench's scenarios can show other behaviours, because each depends on history held in the table:
- the exact delayed value for each command duration;
- overwrite by the latest command;
- the precharge-all broadcast and its maximum over banks;
- the same-cycle ordering of issue and query;
- that unused issue codes are ignored.

// File: rtl/occ_pkg.sv
package occ_pkg;

    typedef enum logic [2:0] {
        CMD_ACT  = 3'd0,
        CMD_RD   = 3'd1,
        CMD_WR   = 3'd2,
        CMD_PRE  = 3'd3,
        CMD_PREA = 3'd4
    } occ_cmd_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ANSWER = 1'b1
    } occ_state_e;

endpackage

// File: rtl/occ_table.sv
module occ_table
    import occ_pkg::*;
#(
    parameter int NBANK   = 8,
    parameter int TIME_W  = 16,
    parameter int T_RCD   = 3,
    parameter int T_RL    = 3,
    parameter int T_RDATA = 2,
    parameter int T_WR    = 8,
    parameter int T_RP    = 4,
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_cmd,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [TIME_W-1:0] wr_start,
    output logic [TIME_W-1:0] end_q  [NBANK],
    output logic              seen_q [NBANK]
);

    localparam logic [TIME_W-1:0] D_ACT = TIME_W'(T_RCD);
    localparam logic [TIME_W-1:0] D_RD  = TIME_W'(T_RL + T_RDATA);
    localparam logic [TIME_W-1:0] D_WR  = TIME_W'(T_WR);
    localparam logic [TIME_W-1:0] D_PRE = TIME_W'(T_RP);

    logic [TIME_W-1:0] dur;
    logic              code_ok;
    logic              to_all;
    logic [TIME_W-1:0] new_end;

    // Busy duration per command type; unused codes are rejected.
    always_comb begin
        dur     = '0;
        code_ok = 1'b1;
        to_all  = 1'b0;
        case (wr_cmd)
            CMD_ACT:  dur = D_ACT;
            CMD_RD:   dur = D_RD;
            CMD_WR:   dur = D_WR;
            CMD_PRE:  dur = D_PRE;
            CMD_PREA: begin
                dur    = D_PRE;
                to_all = 1'b1;
            end
            default:  code_ok = 1'b0;
        endcase
    end

    assign new_end = wr_start + dur;

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic hit;
        assign hit = wr_en && code_ok && (to_all || (wr_bank == BANK_W'(g)));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                end_q[g]  <= '0;
                seen_q[g] <= 1'b0;
            end else if (hit) begin
                end_q[g]  <= new_end;
                seen_q[g] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/occ_lookup.sv
module occ_lookup
    import occ_pkg::*;
#(
    parameter int NBANK   = 8,
    parameter int TIME_W  = 16,
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic [2:0]        kind,
    input  logic [BANK_W-1:0] bank,
    input  logic [TIME_W-1:0] start,
    input  logic [TIME_W-1:0] end_q  [NBANK],
    input  logic              seen_q [NBANK],
    output logic [TIME_W-1:0] adj
);

    logic [TIME_W-1:0] one_bank;
    logic [TIME_W-1:0] all_bank;

    always_comb begin
        one_bank = start;
        all_bank = start;
        for (int b = 0; b < NBANK; b++) begin
            if (seen_q[b] && (end_q[b] > start) && (bank == BANK_W'(b)))
                one_bank = end_q[b];
            if (seen_q[b] && (end_q[b] > all_bank))
                all_bank = end_q[b];
        end
        case (kind)
            CMD_RD, CMD_PRE: adj = one_bank;
            CMD_PREA:        adj = all_bank;
            default:         adj = start;
        endcase
    end

endmodule

// File: rtl/occ_checker.sv
module occ_checker
    import occ_pkg::*;
#(
    parameter int NBANK   = 8,
    parameter int TIME_W  = 16,
    parameter int T_RCD   = 3,
    parameter int T_RL    = 3,
    parameter int T_RDATA = 2,
    parameter int T_WR    = 8,
    parameter int T_RP    = 4,
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              qry_valid,
    input  logic [2:0]        qry_kind,
    input  logic [BANK_W-1:0] qry_bank,
    input  logic [TIME_W-1:0] qry_start,
    input  logic              iss_valid,
    input  logic [2:0]        iss_cmd,
    input  logic [BANK_W-1:0] iss_bank,
    input  logic [TIME_W-1:0] iss_start,
    output logic              ans_valid,
    output logic [TIME_W-1:0] ans_start
);

    logic [TIME_W-1:0] end_q  [NBANK];
    logic              seen_q [NBANK];
    logic [TIME_W-1:0] adj;
    occ_state_e        state, state_nx;

    occ_table #(
        .NBANK(NBANK), .TIME_W(TIME_W), .T_RCD(T_RCD), .T_RL(T_RL),
        .T_RDATA(T_RDATA), .T_WR(T_WR), .T_RP(T_RP)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(iss_valid), .wr_cmd(iss_cmd),
        .wr_bank(iss_bank), .wr_start(iss_start),
        .end_q(end_q), .seen_q(seen_q)
    );

    occ_lookup #(.NBANK(NBANK), .TIME_W(TIME_W)) u_lookup (
        .kind(qry_kind), .bank(qry_bank), .start(qry_start),
        .end_q(end_q), .seen_q(seen_q), .adj(adj)
    );

    // Next-state selection.
    always_comb begin
        unique case (state)
            ST_IDLE:   state_nx = qry_valid ? ST_ANSWER : ST_IDLE;
            ST_ANSWER: state_nx = qry_valid ? ST_ANSWER : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Answer capture: the lookup sees the table before any same-cycle issue.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ans_start <= '0;
        else if (qry_valid) ans_start <= adj;
    end

    // Outputs.
    always_comb begin
        unique case (state)
            ST_ANSWER: ans_valid = 1'b1;
            default:   ans_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/occ_checker_sva.sv
module occ_checker_sva
    import occ_pkg::*;
#(
    parameter int TIME_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              qry_valid,
    input logic [2:0]        qry_kind,
    input logic [TIME_W-1:0] qry_start,
    input logic              ans_valid,
    input logic [TIME_W-1:0] ans_start
);

    AST_ANSWER_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        qry_valid |=> ans_valid);                                                  // R2
    AST_NO_SPURIOUS_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        !qry_valid |=> !ans_valid);                                                // R2
    AST_NEVER_EARLIER: assert property (@(posedge clk) disable iff (!rst_n)
        qry_valid |=> (ans_start >= $past(qry_start)));                            // R3
    AST_OTHER_KIND_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_valid && (qry_kind == CMD_ACT || qry_kind == CMD_WR))
            |=> (ans_start == $past(qry_start)));                                  // R10

endmodule

bind occ_checker occ_checker_sva #(.TIME_W(TIME_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .qry_valid(qry_valid), .qry_kind(qry_kind),
    .qry_start(qry_start), .ans_valid(ans_valid), .ans_start(ans_start)
);

// File: tb/occ_checker_bench.sv
module occ_checker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NBANK  = 8;
    localparam int TIME_W = 16;
    localparam int BANK_W = 3;
    localparam int D_ACT = 3, D_RD = 5, D_WR = 8, D_PRE = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              qry_valid = 1'b0;
    logic [2:0]        qry_kind = '0;
    logic [BANK_W-1:0] qry_bank = '0;
    logic [TIME_W-1:0] qry_start = '0;
    logic              iss_valid = 1'b0;
    logic [2:0]        iss_cmd = '0;
    logic [BANK_W-1:0] iss_bank = '0;
    logic [TIME_W-1:0] iss_start = '0;
    logic              ans_valid;
    logic [TIME_W-1:0] ans_start;

    int total = 0;
    int bad   = 0;
    string cur_req = "R1";

    occ_checker u_occ_checker (
        .clk(clk), .rst_n(rst_n),
        .qry_valid(qry_valid), .qry_kind(qry_kind), .qry_bank(qry_bank), .qry_start(qry_start),
        .iss_valid(iss_valid), .iss_cmd(iss_cmd), .iss_bank(iss_bank), .iss_start(iss_start),
        .ans_valid(ans_valid), .ans_start(ans_start)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model.
    int m_end  [NBANK];
    bit m_seen [NBANK];
    bit exp_valid = 0;
    int exp_start = 0;

    function automatic int model_answer(int kind, int bank, int start);
        int r = start;
        if (kind == 1 || kind == 3) begin
            if (m_seen[bank] && m_end[bank] > r) r = m_end[bank];
        end else if (kind == 4) begin
            for (int b = 0; b < NBANK; b++)
                if (m_seen[b] && m_end[b] > r) r = m_end[b];
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_valid = 0;
            for (int b = 0; b < NBANK; b++) begin m_end[b] = 0; m_seen[b] = 0; end
        end else begin
            exp_valid = qry_valid;
            if (qry_valid) exp_start = model_answer(qry_kind, qry_bank, qry_start);
            if (iss_valid && iss_cmd <= 3'd4) begin
                int d;
                case (iss_cmd)
                    3'd0: d = D_ACT;
                    3'd1: d = D_RD;
                    3'd2: d = D_WR;
                    default: d = D_PRE;
                endcase
                for (int b = 0; b < NBANK; b++)
                    if (iss_cmd == 3'd4 || b == int'(iss_bank)) begin
                        m_end[b] = int'(iss_start) + d;
                        m_seen[b] = 1;
                    end
            end
        end
    end

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            total++;
            if (ans_valid !== exp_valid || (exp_valid && int'(ans_start) != exp_start)) begin
                bad++;
                $display("FAIL %s model compare: valid=%0b start=%0d expected valid=%0b start=%0d",
                         cur_req, ans_valid, ans_start, exp_valid, exp_start);
            end
        end
    end

    task automatic check(string req, int got, int expv, string what);
        total++;
        if (got != expv) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, expv);
        end
    endtask

    task automatic issue(int cmd, int bank, int start);
        @(negedge clk);
        iss_valid = 1'b1; iss_cmd = 3'(cmd); iss_bank = BANK_W'(bank); iss_start = TIME_W'(start);
        @(negedge clk);
        iss_valid = 1'b0;
    endtask

    task automatic ask(string req, int kind, int bank, int start, int expv);
        cur_req = req;
        @(negedge clk);
        qry_valid = 1'b1; qry_kind = 3'(kind); qry_bank = BANK_W'(bank); qry_start = TIME_W'(start);
        @(negedge clk);
        qry_valid = 1'b0;
        check(req, int'(ans_valid), 1, "answer valid");
        check(req, int'(ans_start), expv, "answer start");
        @(negedge clk);
        check(req, int'(ans_valid), 0, "answer lasts one cycle");
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", int'(ans_valid), 0, "valid in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(ans_valid), 0, "valid after reset");
        ask("R1", 1, 0, 10, 10);
        ask("R5", 3, 3, 12, 12);

        issue(1, 2, 100);                  // read ends at 105
        ask("R3", 1, 2, 101, 105);
        ask("R3", 1, 2, 107, 107);
        ask("R4", 3, 2, 101, 105);          // precharge starts when read ends

        issue(0, 1, 200);  ask("R6", 3, 1, 200, 203);
        issue(2, 4, 300);  ask("R6", 1, 4, 301, 308);
        issue(3, 5, 400);  ask("R6", 1, 5, 400, 404);

        issue(2, 6, 500);
        issue(0, 6, 501);                  // overwrite: end 504, not 508
        ask("R9", 1, 6, 502, 504);
        ask("R10", 2, 6, 502, 502);
        ask("R10", 0, 6, 502, 502);

        // R11: issue and query together on an unrecorded bank.
        cur_req = "R11";
        @(negedge clk);
        iss_valid = 1'b1; iss_cmd = 3'd1; iss_bank = 3'd7; iss_start = 16'd600;
        qry_valid = 1'b1; qry_kind = 3'd1; qry_bank = 3'd7; qry_start = 16'd600;
        @(negedge clk);
        iss_valid = 1'b0; qry_valid = 1'b0;
        check("R11", int'(ans_start), 600, "same-cycle issue not seen");
        ask("R11", 1, 7, 600, 605);

        issue(5, 3, 700);
        issue(7, 3, 700);
        ask("R12", 1, 3, 700, 700);

        ask("R8", 4, 0, 800, 800);
        ask("R8", 4, 3, 300, 605);
        issue(4, 0, 900);
        ask("R7", 1, 0, 901, 904);
        ask("R7", 1, 3, 900, 904);
        ask("R7", 3, 7, 902, 904);

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule